// File: doc/BRIEF.md
# Four-Port Control and Status Register Bank

This block is the byte-wide register file of a four-port cell-interface device. A simple parallel utility bus reaches it. The bus carries an address, separate read and write strobes, write data and read data. Each port has its own window of nine registers: a master control byte, a sticky interrupt status byte, a diagnostic byte, a live link status byte, the two bytes of a cell counter, a counter select byte, an interrupt mask byte and an enhanced control byte. One more register, shared by every port, sits just above the four windows. The cell datapath and the counters are outside the block. Their values enter only as status inputs.

Hardware events set bits in each port's status register, and those bits stay set until software reads the register. The block combines each port's status with that port's mask and master control bits. The result from all four ports drives a single active-low interrupt line. That line can be switched off for a port, or limited to the received-cell-error event alone. The control and enhanced control bytes of the port that the cell interface currently selects are exported, so the datapath always runs with the settings of the active port.

Top module: `ctl_regbank`

## Requirements
- R1: The registers of port p (0 to 3) sit at address 0x10*p + offset, for offsets 0x0 to 0x8. The shared register sits at 0x40. Read data appears on `bus_rdata` in the cycle after the cycle in which `bus_rd` is high, and it holds until the next read.
- R2: A read of any other address (offsets 0x9 to 0xF of a port window, or 0x41 to 0x7F) returns 0x00. A write to such an address changes no register.
- R3: The read/write registers come out of reset at 0x00. These are: control (offset 0x0), diagnostic (0x2), counter select (0x6), mask (0x7), enhanced control (0x8) and the shared register (0x40). Control bit 7 and counter select bits 7:4 are reserved. They read 0, and writes to them are dropped. All other bits read back as written.
- R4: Offset 0x3 returns the port's live link status byte. Offsets 0x4 and 0x5 return bits 7:0 and bits 15:8 of the port's cell count input. Writes to offsets 0x1, 0x3, 0x4 and 0x5 have no effect.
- R5: Offset 0x1 is the sticky status register. A high event bit sets the matching status bit, which then stays set. A read of the register returns its contents and clears it.
- R6: If an event sets a status bit in the same cycle as a read of that status register, the read returns the old contents and the newly set bit remains set afterwards.
- R7: `irq_n` is low exactly when some port has control bit 0 set and a nonzero AND of its status and mask. Otherwise it is high. It follows the register state without an extra cycle of delay.
- R8: When control bit 6 of a port is set, only status bit 0 (received cell error) of that port can take part in the interrupt.
- R9: Control bit 0 has no effect on how status bits are captured or read.
- R10: `sel_ctl` and `sel_enh` show, combinationally, the control and enhanced control registers of the port given by `sel_port`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 7 | Utility bus address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sel_port | input | 2 | Port currently selected by the cell interface |
| evt_status | input | 32 | Status event pulses, byte p for port p |
| link_status | input | 32 | Live link status, byte p for port p |
| cell_count | input | 64 | Cell counter values, 16 bits per port |
| sel_ctl | output | 8 | Control register of the selected port |
| sel_enh | output | 8 | Enhanced control register of the selected port |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
The assertions assume that the bus strobes are single-cycle pulses with a stable address while they are high. They also assume that event inputs are synchronous pulses, and that a read and a write do not target the same status register with events pending in a way the sticky checks would misread. The bench drives every strobe for exactly one cycle from the falling edge. It holds the event inputs at zero except in deliberate pulse cycles, and it keeps the link and counter inputs constant, so that every read value can be predicted from a model held in the bench. The coincident event-and-read case is the only place where an event and a read overlap on purpose.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int DW    = 8;
    localparam int OFF_W = 4;

    // per-port register offsets (the order fixes the address map)
    localparam logic [OFF_W-1:0] OFF_CTL  = 4'h0;
    localparam logic [OFF_W-1:0] OFF_STS  = 4'h1;
    localparam logic [OFF_W-1:0] OFF_DIAG = 4'h2;
    localparam logic [OFF_W-1:0] OFF_LINK = 4'h3;
    localparam logic [OFF_W-1:0] OFF_CNTL = 4'h4;
    localparam logic [OFF_W-1:0] OFF_CNTH = 4'h5;
    localparam logic [OFF_W-1:0] OFF_CSEL = 4'h6;
    localparam logic [OFF_W-1:0] OFF_MASK = 4'h7;
    localparam logic [OFF_W-1:0] OFF_ENH  = 4'h8;
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_ENH;

    localparam int PORT_STRIDE = 1 << OFF_W;

    // control bit positions
    localparam int CTL_IRQ_EN   = 0;
    localparam int CTL_ERR_ONLY = 6;
    localparam int STS_CELL_ERR = 0;

    // writable-bit masks (reserved bits are zero here)
    localparam logic [DW-1:0] CTL_WMASK  = 8'h7F;
    localparam logic [DW-1:0] CSEL_WMASK = 8'h0F;

    typedef struct packed {
        logic [DW-1:0] ctl;
        logic [DW-1:0] sts;
        logic [DW-1:0] diag;
        logic [DW-1:0] csel;
        logic [DW-1:0] mask;
        logic [DW-1:0] enh;
    } port_regs_t;

    typedef struct packed {
        logic [DW-1:0] shared;
        logic [DW-1:0] rdata;
    } top_regs_t;

endpackage

// File: rtl/rb_addr_decode.sv
module rb_addr_decode
    import regbank_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int PB = $clog2(NUM_PORTS),
    localparam int SHARED_ADDR = NUM_PORTS * PORT_STRIDE,
    localparam int AW = $clog2(SHARED_ADDR + 1)
) (
    input  logic [AW-1:0]        addr,
    output logic [NUM_PORTS-1:0] port_hit,
    output logic                 shared_hit,
    output logic [OFF_W-1:0]     off
);

    logic          in_port_space;
    logic [PB-1:0] port_idx;

    always_comb begin
        off           = addr[OFF_W-1:0];
        port_idx      = addr[OFF_W +: PB];
        in_port_space = (addr < AW'(SHARED_ADDR));
        shared_hit    = (addr == AW'(SHARED_ADDR));
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
        assign port_hit[p] = in_port_space && (port_idx == PB'(p)) && (off <= OFF_LAST);
    end

    always_comb begin
        assert_hit_onehot_R1: assert ($onehot0({port_hit, shared_hit}));
    end

endmodule

// File: rtl/rb_port_regs.sv
module rb_port_regs
    import regbank_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int CNT_EXT = 2 * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFF_W-1:0] off,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    evt,
    input  logic [DW-1:0]    link,
    input  logic [CNT_W-1:0] cnt,
    output logic [DW-1:0]    rdata,
    output logic [DW-1:0]    ctl_o,
    output logic [DW-1:0]    enh_o,
    output logic             irq_o
);

    port_regs_t r_d, r_q;
    logic [CNT_EXT-1:0] cnt_ext;
    logic [DW-1:0]      sts_keep;
    logic [DW-1:0]      irq_src;
    logic               sts_rd;

    always_comb begin
        cnt_ext  = CNT_EXT'(cnt);
        sts_rd   = rd_en && (off == OFF_STS);
        sts_keep = sts_rd ? '0 : r_q.sts;
        r_d      = r_q;
        r_d.sts  = sts_keep | evt;
        if (wr_en) begin
            case (off)
                OFF_CTL:  r_d.ctl  = wdata & CTL_WMASK;
                OFF_DIAG: r_d.diag = wdata;
                OFF_CSEL: r_d.csel = wdata & CSEL_WMASK;
                OFF_MASK: r_d.mask = wdata;
                OFF_ENH:  r_d.enh  = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (off)
            OFF_CTL:  rdata = r_q.ctl;
            OFF_STS:  rdata = r_q.sts;
            OFF_DIAG: rdata = r_q.diag;
            OFF_LINK: rdata = link;
            OFF_CNTL: rdata = cnt_ext[DW-1:0];
            OFF_CNTH: rdata = cnt_ext[CNT_EXT-1:DW];
            OFF_CSEL: rdata = r_q.csel;
            OFF_MASK: rdata = r_q.mask;
            OFF_ENH:  rdata = r_q.enh;
            default:  rdata = '0;
        endcase
    end

    always_comb begin
        irq_src = r_q.sts & r_q.mask;
        if (r_q.ctl[CTL_ERR_ONLY]) irq_src = irq_src & (DW'(1) << STS_CELL_ERR);
        irq_o = r_q.ctl[CTL_IRQ_EN] && (|irq_src);
        ctl_o = r_q.ctl;
        enh_o = r_q.enh;
    end

    assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && off == OFF_STS) |=> ((r_q.sts & $past(r_q.sts)) == $past(r_q.sts)));
    assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && off == OFF_STS && evt == '0) |=> (r_q.sts == '0));
    assert_event_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((r_q.sts & $past(evt)) == $past(evt)));
    assert_sts_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_STS && !rd_en && evt == '0) |=> $stable(r_q.sts));
    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctl_o[CTL_IRQ_EN]);
    assert_err_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ctl_o[CTL_ERR_ONLY]) |-> (r_q.sts[STS_CELL_ERR] && r_q.mask[STS_CELL_ERR]));
    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[DW-1] == 1'b0) && (r_q.csel[DW-1:4] == '0));

endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
    import regbank_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int CNT_W     = 16,
    localparam int PB = $clog2(NUM_PORTS),
    localparam int SHARED_ADDR = NUM_PORTS * PORT_STRIDE,
    localparam int AW = $clog2(SHARED_ADDR + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              bus_addr,
    input  logic                       bus_rd,
    input  logic                       bus_wr,
    input  logic [DW-1:0]              bus_wdata,
    output logic [DW-1:0]              bus_rdata,
    input  logic [PB-1:0]              sel_port,
    input  logic [NUM_PORTS*DW-1:0]    evt_status,
    input  logic [NUM_PORTS*DW-1:0]    link_status,
    input  logic [NUM_PORTS*CNT_W-1:0] cell_count,
    output logic [DW-1:0]              sel_ctl,
    output logic [DW-1:0]              sel_enh,
    output logic                       irq_n
);

    logic [NUM_PORTS-1:0] port_hit;
    logic                 shared_hit;
    logic [OFF_W-1:0]     off;
    logic [DW-1:0]        port_rdata [NUM_PORTS];
    logic [DW-1:0]        ctl_arr    [NUM_PORTS];
    logic [DW-1:0]        enh_arr    [NUM_PORTS];
    logic [NUM_PORTS-1:0] port_irq;
    logic [NUM_PORTS-1:0] irq_en_vec;
    logic [DW-1:0]        rd_mux;
    top_regs_t            t_d, t_q;

    rb_addr_decode #(.NUM_PORTS(NUM_PORTS)) u_dec (
        .addr       (bus_addr),
        .port_hit   (port_hit),
        .shared_hit (shared_hit),
        .off        (off)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rb_port_regs #(.CNT_W(CNT_W)) u_port (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_wr && port_hit[p]),
            .rd_en (bus_rd && port_hit[p]),
            .off   (off),
            .wdata (bus_wdata),
            .evt   (evt_status[p*DW +: DW]),
            .link  (link_status[p*DW +: DW]),
            .cnt   (cell_count[p*CNT_W +: CNT_W]),
            .rdata (port_rdata[p]),
            .ctl_o (ctl_arr[p]),
            .enh_o (enh_arr[p]),
            .irq_o (port_irq[p])
        );
        assign irq_en_vec[p] = ctl_arr[p][CTL_IRQ_EN];
    end

    always_comb begin
        rd_mux = shared_hit ? t_q.shared : '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_hit[p]) rd_mux = rd_mux | port_rdata[p];
        end
        t_d = t_q;
        if (bus_wr && shared_hit) t_d.shared = bus_wdata;
        if (bus_rd)               t_d.rdata  = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    always_comb begin
        bus_rdata = t_q.rdata;
        sel_ctl   = ctl_arr[sel_port];
        sel_enh   = enh_arr[sel_port];
        irq_n     = ~(|port_irq);
    end

    assert_unmapped_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !shared_hit && port_hit == '0) |=> (bus_rdata == '0));
    assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_vec == '0) |-> irq_n);
    assert_shared_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !shared_hit) |=> $stable(t_q.shared));

endmodule

// File: tb/sim_ctl_regbank.sv
module sim_ctl_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  sel_port = '0;
    logic [31:0] evt_status = '0;
    logic [31:0] link_status;
    logic [63:0] cell_count;
    logic [7:0]  sel_ctl, sel_enh;
    logic        irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench model
    logic [7:0] m_ctl [4], m_sts [4], m_diag [4], m_csel [4], m_mask [4], m_enh [4];
    logic [7:0] m_shared;

    always #4 clk = ~clk;

    ctl_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sel_port(sel_port),
        .evt_status(evt_status), .link_status(link_status), .cell_count(cell_count),
        .sel_ctl(sel_ctl), .sel_enh(sel_enh), .irq_n(irq_n)
    );

    function automatic logic [7:0] link_of(int p);
        return 8'h3C ^ 8'(p * 17);
    endfunction
    function automatic logic [15:0] cnt_of(int p);
        return 16'h1234 + 16'(p * 16'h1111);
    endfunction

    initial begin
        for (int p = 0; p < 4; p++) begin
            link_status[p*8 +: 8]  = link_of(p);
            cell_count[p*16 +: 16] = cnt_of(p);
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(int a);
        int p, o;
        if (a == 64) return m_shared;
        if (a > 63) return 8'h00;
        p = a / 16; o = a % 16;
        case (o)
            0: return m_ctl[p];
            1: return m_sts[p];
            2: return m_diag[p];
            3: return link_of(p);
            4: return cnt_of(p)[7:0];
            5: return cnt_of(p)[15:8];
            6: return m_csel[p];
            7: return m_mask[p];
            8: return m_enh[p];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_of(int a);
        int o;
        if (a == 64) return "R3";
        if (a > 63) return "R2";
        o = a % 16;
        if (o > 8) return "R2";
        if (o == 1) return "R5";
        if (o >= 3 && o <= 5) return "R4";
        return "R3";
    endfunction

    function automatic logic m_irq_n();
        logic any = 1'b0;
        logic [7:0] act;
        for (int p = 0; p < 4; p++) begin
            act = m_sts[p] & m_mask[p];
            if (m_ctl[p][6]) act = act & 8'h01;
            if (m_ctl[p][0] && act != 0) any = 1'b1;
        end
        return ~any;
    endfunction

    task automatic bus_write(int a, logic [7:0] d);
        int p, o;
        @(negedge clk);
        bus_addr = 7'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 64) m_shared = d;
        else if (a < 64) begin
            p = a / 16; o = a % 16;
            case (o)
                0: m_ctl[p]  = d & 8'h7F;
                2: m_diag[p] = d;
                6: m_csel[p] = d & 8'h0F;
                7: m_mask[p] = d;
                8: m_enh[p]  = d;
                default: ;
            endcase
        end
    endtask

    task automatic bus_read(int a, string req);
        logic [7:0] exp;
        exp = m_read(a);
        @(negedge clk);
        bus_addr = 7'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, bus_rdata, exp);
        if (a < 64 && a % 16 == 1) m_sts[a / 16] = 8'h00;
    endtask

    task automatic pulse_evt(int p, logic [7:0] bits);
        @(negedge clk);
        evt_status[p*8 +: 8] = bits;
        @(negedge clk);
        evt_status = '0;
        m_sts[p] = m_sts[p] | bits;
    endtask

    initial begin
        for (int p = 0; p < 4; p++) begin
            m_ctl[p] = 0; m_sts[p] = 0; m_diag[p] = 0;
            m_csel[p] = 0; m_mask[p] = 0; m_enh[p] = 0;
        end
        m_shared = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R3, R7, R10)
        chk("R3 rdata after reset", bus_rdata, 8'h00);
        chk("R7 irq_n after reset", {7'b0, irq_n}, 8'h01);
        chk("R10 sel_ctl after reset", sel_ctl, 8'h00);

        // exhaustive read sweep after reset (R1..R4)
        for (int a = 0; a < 128; a++) bus_read(a, req_of(a));

        // R1: read data holds with no strobe
        bus_read(3, "R1");
        repeat (3) @(negedge clk);
        chk("R1 rdata hold", bus_rdata, link_of(0));

        // exhaustive write sweep, then read sweep (R1..R4, R2 writes ignored)
        for (int a = 0; a < 128; a++) bus_write(a, 8'(a * 73 + 29));
        for (int a = 0; a < 128; a++) bus_read(a, req_of(a));

        // R10: selected port exports
        for (int p = 0; p < 4; p++) begin
            bus_write(p * 16, 8'hF0 | 8'(p));
            bus_write(p * 16 + 8, 8'h5A ^ 8'(p * 3));
        end
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            sel_port = 2'(p);
            #1;
            chk("R10 sel_ctl", sel_ctl, m_ctl[p]);
            chk("R10 sel_enh", sel_enh, m_enh[p]);
        end

        // clear control and mask everywhere before interrupt sweep
        for (int p = 0; p < 4; p++) begin
            bus_write(p * 16, 8'h00);
            bus_write(p * 16 + 7, 8'h00);
        end
        chk("R7 irq_n idle", {7'b0, irq_n}, {7'b0, m_irq_n()});

        // interrupt sweep (R5, R7, R8, R9)
        for (int p = 0; p < 4; p++) begin
            for (int cfg = 0; cfg < 4; cfg++) begin
                for (int mi = 0; mi < 4; mi++) begin
                    for (int si = 0; si < 3; si++) begin
                        logic [7:0] mv, sv;
                        mv = (mi == 0) ? 8'h00 : (mi == 1) ? 8'h01 : (mi == 2) ? 8'hFE : 8'hFF;
                        sv = (si == 0) ? 8'h01 : (si == 1) ? 8'h80 : 8'h81;
                        bus_write(p * 16, {1'b0, cfg[1] ? 1'b1 : 1'b0, 5'b0, cfg[0] ? 1'b1 : 1'b0});
                        bus_write(p * 16 + 7, mv);
                        pulse_evt(p, sv);
                        chk(cfg[1] ? "R8 irq_n err-only" : "R7 irq_n", {7'b0, irq_n}, {7'b0, m_irq_n()});
                        bus_read(p * 16 + 1, cfg[0] ? "R5 sticky read" : "R9 sticky read irq off");
                        bus_read(p * 16 + 1, "R5 cleared by read");
                        chk("R7 irq_n after clear", {7'b0, irq_n}, {7'b0, m_irq_n()});
                    end
                end
            end
            bus_write(p * 16, 8'h00);
        end

        // R4: write to status register has no effect
        pulse_evt(1, 8'h24);
        bus_write(16 + 1, 8'hFF);
        bus_read(16 + 1, "R4 status write ignored");

        // R6: event coincident with read of status
        pulse_evt(2, 8'h08);
        @(negedge clk);
        bus_addr = 7'(32 + 1); bus_rd = 1'b1;
        evt_status[2*8 +: 8] = 8'h20;
        @(negedge clk);
        bus_rd = 1'b0; evt_status = '0;
        chk("R6 read returns old", bus_rdata, 8'h08);
        m_sts[2] = 8'h20;
        bus_read(32 + 1, "R6 new bit kept");
        bus_read(32 + 1, "R6 cleared afterwards");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule